// File: doc/BRIEF.md
# Front-Panel LED Serial Shifter

This block turns a small set of front-panel status requests into an 8-bit LED pattern. It then clocks the pattern, one bit at a time, into an external 8-bit serial-in shift register. The requests are four disk-fault flags and a system LED colour, which can be off, blue or red. The block drives two wires: a serial data line and a shift clock line. The disk-activity LEDs are not handled here; other logic drives them.

A one-cycle `update` strobe starts a transfer. At the start of the transfer the block samples the request inputs and encodes them through a fixed bit map. It then sends the eight bits least-significant first. Before each clock pulse the data line holds its bit for a programmable setup time, and each clock pulse stays high for a programmable time. Both times are whole numbers of microsecond ticks, and one tick is a parameterised count of system clock cycles. While a transfer runs, `busy` is high. A strobe that arrives while `busy` is high is remembered and served as soon as the current transfer ends.

Top module: `panel_led_shifter`

## Requirements
- R1: While reset is asserted and right after it is released, `ledData`, `ledClk` and `busy` are all low.
- R2: Pattern bits 0 and 7 are always 1.
- R3: `sysColor` code 1 (blue) sets pattern bit 2 and code 2 (red) sets pattern bit 3. Codes 0 (off) and 3 (reserved) set neither bit.
- R4: `diskRed[i]` high means disk i+1 is red, and that disk's bit is then 0. When the disk is not red, the bit is 1. The bit positions are: disk 1 is bit 1, disk 2 is bit 6, disk 3 is bit 5 and disk 4 is bit 4.
- R5: Each transfer gives exactly 8 rising edges on `ledClk`. The value of `ledData` at the k-th rising edge is pattern bit k-1, so bits go out least-significant first.
- R6: Before each rising edge, `ledClk` is low for exactly SETUP_US*CLK_PER_US cycles. It then stays high for exactly HIGH_US*CLK_PER_US cycles. `ledData` does not change while `ledClk` is high.
- R7: `busy` goes high in the cycle after an accepted strobe and falls after the last clock pulse ends. Whenever `busy` is low, `ledClk` and `ledData` are low.
- R8: Strobes that arrive while `busy` is high cause exactly one further transfer, however many there are. That transfer starts one idle cycle after the current one ends.
- R9: Request inputs are sampled only when a transfer starts. Changing them during a transfer, or while idle with no strobe, has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| update | input | 1 | One-cycle request to send a new pattern |
| diskRed | input | 4 | Fault flag per disk; bit i is disk i+1 |
| sysColor | input | 2 | System LED colour: 0 off, 1 blue, 2 red, 3 off |
| busy | output | 1 | High while a transfer is in progress |
| ledData | output | 1 | Serial data to the external shift register |
| ledClk | output | 1 | Shift clock to the external shift register |

## Verification
The assertions check the line discipline on every cycle:
- the lines are quiet in reset and whenever the block is idle;
- data is stable while the clock is high;
- clock pulses happen only while busy;
- every high phase has the exact programmed length.

The bit encoding, the bit order, the exact low-phase length and the strobe queueing can only be shown by the bench's scenarios. The bench rebuilds each byte from the clock edges and compares it with a pattern computed from the bit map. It also checks that strobes during a transfer give exactly one follow-on transfer with the inputs present when that transfer starts.

// File: rtl/ledsh_pkg.sv
package ledsh_pkg;

  localparam int PAT_W     = 8;
  localparam int NUM_DISKS = 4;

  // Bit map of the external register
  localparam logic [PAT_W-1:0] BASE_MASK = 8'h81;
  localparam int SYS_BLUE_BIT = 2;
  localparam int SYS_RED_BIT  = 3;

  typedef enum logic [1:0] {
    SYS_OFF  = 2'd0,
    SYS_BLUE = 2'd1,
    SYS_RED  = 2'd2,
    SYS_RSVD = 2'd3
  } sysColor_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture pattern, present bit 0
    logic clkRise;  // raise shift clock
    logic clkFall;  // lower shift clock, advance
    logic lastBit;  // this fall ends the transfer
  } shiftCtl_t;

  function automatic int diskPos(input int idx);
    case (idx)
      0:       return 1;
      1:       return 6;
      2:       return 5;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/ledsh_timer.sv
module ledsh_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic [TW-1:0] loadVal,
  output logic          done
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (load)      cnt <= loadVal;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/ledsh_ctrl.sv
module ledsh_ctrl
  import ledsh_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int HIGH_CYC  = 4,
  parameter int TW        = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          update,
  input  logic          timerDone,
  output logic          timerLoad,
  output logic [TW-1:0] timerVal,
  output shiftCtl_t     ctl,
  output logic          busy
);

  localparam int BCW = $clog2(PAT_W);
  localparam logic [BCW-1:0] LAST_IDX = BCW'(PAT_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_HIGH} state_e;

  state_e        state, stateNext;
  logic [BCW-1:0] bitCnt, bitCntNext;
  logic          pending, pendingNext;

  always_comb begin
    stateNext   = state;
    bitCntNext  = bitCnt;
    pendingNext = pending;
    timerLoad   = 1'b0;
    timerVal    = TW'(SETUP_CYC - 1);
    ctl         = '0;
    unique case (state)
      ST_IDLE: begin
        if (update || pending) begin
          ctl.load    = 1'b1;
          timerLoad   = 1'b1;
          timerVal    = TW'(SETUP_CYC - 1);
          bitCntNext  = '0;
          pendingNext = 1'b0;
          stateNext   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (update) pendingNext = 1'b1;
        if (timerDone) begin
          ctl.clkRise = 1'b1;
          timerLoad   = 1'b1;
          timerVal    = TW'(HIGH_CYC - 1);
          stateNext   = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (update) pendingNext = 1'b1;
        if (timerDone) begin
          ctl.clkFall = 1'b1;
          if (bitCnt == LAST_IDX) begin
            ctl.lastBit = 1'b1;
            stateNext   = ST_IDLE;
          end else begin
            bitCntNext = bitCnt + 1'b1;
            timerLoad  = 1'b1;
            timerVal   = TW'(SETUP_CYC - 1);
            stateNext  = ST_SETUP;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      bitCnt  <= bitCntNext;
      pending <= pendingNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ledsh_datapath.sv
module ledsh_datapath
  import ledsh_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_DISKS-1:0] diskRed,
  input  logic [1:0]           sysColor,
  input  shiftCtl_t            ctl,
  output logic                 ledData,
  output logic                 ledClk
);

  logic [PAT_W-1:0] diskBits;
  logic [PAT_W-1:0] pattern;
  logic [PAT_W-1:0] shiftReg;

  // One bit per disk, set when that disk is not red
  for (genvar g = 0; g < NUM_DISKS; g++) begin : g_disk
    localparam int POS = diskPos(g);
    logic [PAT_W-1:0] oneDisk;
    always_comb begin
      oneDisk      = '0;
      oneDisk[POS] = ~diskRed[g];
    end
  end

  always_comb begin
    diskBits = g_disk[0].oneDisk | g_disk[1].oneDisk
             | g_disk[2].oneDisk | g_disk[3].oneDisk;
  end

  always_comb begin
    pattern = BASE_MASK | diskBits;
    case (sysColor_e'(sysColor))
      SYS_BLUE: pattern[SYS_BLUE_BIT] = 1'b1;
      SYS_RED:  pattern[SYS_RED_BIT]  = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ledData  <= 1'b0;
      ledClk   <= 1'b0;
    end else begin
      if (ctl.load) begin
        shiftReg <= pattern;
        ledData  <= pattern[0];
      end
      if (ctl.clkRise) ledClk <= 1'b1;
      if (ctl.clkFall) begin
        ledClk   <= 1'b0;
        shiftReg <= shiftReg >> 1;
        ledData  <= ctl.lastBit ? 1'b0 : shiftReg[1];
      end
    end
  end

endmodule

// File: rtl/panel_led_shifter.sv
module panel_led_shifter
  import ledsh_pkg::*;
#(
  parameter int CLK_PER_US = 4,
  parameter int SETUP_US   = 1,
  parameter int HIGH_US    = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       update,
  input  logic [3:0] diskRed,
  input  logic [1:0] sysColor,
  output logic       busy,
  output logic       ledData,
  output logic       ledClk
);

  localparam int SETUP_CYC = (CLK_PER_US * SETUP_US < 1) ? 1 : CLK_PER_US * SETUP_US;
  localparam int HIGH_CYC  = (CLK_PER_US * HIGH_US  < 1) ? 1 : CLK_PER_US * HIGH_US;
  localparam int MAX_CYC   = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int TW        = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  shiftCtl_t     ctl;
  logic          timerLoad;
  logic [TW-1:0] timerVal;
  logic          timerDone;

  ledsh_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .HIGH_CYC (HIGH_CYC),
    .TW       (TW)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .update   (update),
    .timerDone(timerDone),
    .timerLoad(timerLoad),
    .timerVal (timerVal),
    .ctl      (ctl),
    .busy     (busy)
  );

  ledsh_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .load   (timerLoad),
    .loadVal(timerVal),
    .done   (timerDone)
  );

  ledsh_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .diskRed (diskRed),
    .sysColor(sysColor),
    .ctl     (ctl),
    .ledData (ledData),
    .ledClk  (ledClk)
  );

endmodule

// File: rtl/panel_led_shifter_chk.sv
module panel_led_shifter_chk #(
  parameter int CLK_PER_US = 4,
  parameter int HIGH_US    = 1
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic ledData,
  input logic ledClk
);

  localparam int HIGH_CYC = (CLK_PER_US * HIGH_US < 1) ? 1 : CLK_PER_US * HIGH_US;

  int highRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       highRun <= 0;
    else if (ledClk) highRun <= highRun + 1;
    else             highRun <= 0;
  end

  // R1: quiet lines during reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (!busy && !ledData && !ledClk));

  // R7: idle implies both lines low
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!ledClk && !ledData));

  // R5: clock pulses only inside a transfer
  p_rise_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ledClk) |-> busy);

  // R6: data held while clock high
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ledClk && $past(ledClk)) |-> $stable(ledData));

  // R6: each high phase has the programmed length
  p_high_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ledClk) |-> (highRun == HIGH_CYC));

endmodule

bind panel_led_shifter panel_led_shifter_chk #(
  .CLK_PER_US(CLK_PER_US),
  .HIGH_US   (HIGH_US)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .ledData(ledData),
  .ledClk (ledClk)
);

// File: tb/panel_led_shifter_tb.sv
module panel_led_shifter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int SETUP_CYC  = CPU;
  localparam int HIGH_CYC   = CPU;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       update = 1'b0;
  logic [3:0] diskRed = 4'h0;
  logic [1:0] sysColor = 2'd0;
  logic       busy, ledData, ledClk;

  int numVec = 0;
  int numFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_led_shifter #(.CLK_PER_US(CPU), .SETUP_US(1), .HIGH_US(1)) u_dut (
    .clk(clk), .rstN(rstN), .update(update), .diskRed(diskRed),
    .sysColor(sysColor), .busy(busy), .ledData(ledData), .ledClk(ledClk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    numVec++;
    if (!ok) begin
      numFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expPat(input logic [3:0] dr, input logic [1:0] col);
    logic [7:0] p;
    p = 8'h81;
    if (col == 2'd1) p = p | 8'h04;
    if (col == 2'd2) p = p | 8'h08;
    if (!dr[0]) p = p | 8'h02;
    if (!dr[1]) p = p | 8'h40;
    if (!dr[2]) p = p | 8'h20;
    if (!dr[3]) p = p | 8'h10;
    return p;
  endfunction

  // Monitor: rebuild bytes from clock edges, measure phases
  logic [7:0] capt [0:15];
  int   captCnt = 0;
  int   nb = 0;
  logic [7:0] acc = 8'h0;
  int   lowCnt = 0;
  logic prevClk = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (ledClk && !prevClk) begin
        check(lowCnt == SETUP_CYC, "R6 setup", lowCnt, SETUP_CYC);
        lowCnt = 0;
        acc = {ledData, acc[7:1]};
        nb++;
        if (nb == 8) begin
          if (captCnt < 16) capt[captCnt] = acc;
          captCnt++;
          nb = 0;
        end
      end
      if (busy && !ledClk) lowCnt++;
      if (!busy) lowCnt = 0;
      prevClk = ledClk;
    end
  end

  task automatic strobe();
    @(negedge clk); update = 1'b1;
    @(negedge clk); update = 1'b0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    for (int i = 0; i < 2000 && quiet < 3; i++) begin
      @(negedge clk);
      if (!busy) quiet++; else quiet = 0;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!busy && !ledData && !ledClk, "R1 in reset", {busy, ledData, ledClk}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !ledData && !ledClk, "R1 after reset", {busy, ledData, ledClk}, 0);
  endtask

  task automatic t_pattern(input logic [3:0] dr, input logic [1:0] col, input string tag);
    logic [7:0] e;
    e = expPat(dr, col);
    diskRed = dr; sysColor = col;
    captCnt = 0; nb = 0;
    strobe();
    check(busy, "R7 busy rises", busy, 1);
    waitIdle();
    check(captCnt == 1 && nb == 0, {tag, " R5 eight pulses"}, captCnt * 8 + nb, 8);
    check(capt[0] == e, {tag, " R5 byte"}, capt[0], e);
    check(!ledClk && !ledData, "R7 idle lines", {ledClk, ledData}, 0);
  endtask

  task automatic t_queue();
    logic [7:0] a, b;
    a = expPat(4'b0101, 2'd1);
    b = expPat(4'b1010, 2'd2);
    diskRed = 4'b0101; sysColor = 2'd1;
    captCnt = 0; nb = 0;
    strobe();
    repeat (20) @(negedge clk);
    diskRed = 4'b1010; sysColor = 2'd2;
    strobe();
    repeat (5) @(negedge clk);
    strobe();
    waitIdle();
    check(captCnt == 2, "R8 one extra transfer", captCnt, 2);
    check(capt[0] == a, "R8 first byte", capt[0], a);
    check(capt[1] == b, "R8 queued byte", capt[1], b);
  endtask

  task automatic t_sampled();
    logic [7:0] a;
    a = expPat(4'b0011, 2'd0);
    diskRed = 4'b0011; sysColor = 2'd0;
    captCnt = 0; nb = 0;
    strobe();
    repeat (30) @(negedge clk);
    diskRed = 4'b1100; sysColor = 2'd2;
    waitIdle();
    check(captCnt == 1 && capt[0] == a, "R9 sampled at start", capt[0], a);
    diskRed = 4'b0000; sysColor = 2'd1;
    repeat (100) @(negedge clk);
    check(captCnt == 1 && nb == 0, "R9 no strobe no transfer", captCnt * 8 + nb, 8);
    check(!busy && !ledClk && !ledData, "R9 lines quiet", {busy, ledClk, ledData}, 0);
  endtask

  initial begin
    t_reset();
    t_pattern(4'b0000, 2'd0, "R2 R4 all clear");
    t_pattern(4'b0000, 2'd1, "R3 blue");
    t_pattern(4'b0000, 2'd2, "R3 red");
    t_pattern(4'b0000, 2'd3, "R3 reserved");
    t_pattern(4'b0001, 2'd0, "R4 disk1");
    t_pattern(4'b0010, 2'd1, "R4 disk2");
    t_pattern(4'b0100, 2'd2, "R4 disk3");
    t_pattern(4'b1000, 2'd0, "R4 disk4");
    t_pattern(4'b1111, 2'd2, "R2 all red");
    t_queue();
    t_sampled();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(negedge clk);
    if (!done) begin
      numVec++;
      numFail++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", numVec, numFail);
    $finish;
  end

endmodule